// File: doc/BRIEF.md
# Round-Robin Request Arbiter with Downstream Stall

The block shares one downstream resource among a set of clients. Each client raises its bit of a request vector. In the same cycle the arbiter answers with a grant vector that selects at most one of them. Grant is a combinational function of the present requests, the stall input and one stored priority pointer, so a client sees its grant in the cycle it is chosen.

When the downstream side raises its stall input, no grant is given and the priority state does not change. Otherwise the winner is the first requesting client found when scanning upward, with wrap-around, from the position just after the client granted last. This gives strict pairwise fairness: a client that won while another was waiting cannot win again until that other client has won. The wait is also bounded, as long as clients keep their requests raised until granted and stall stretches stay short.

The design carries its own embedded protocol checks for each of these rules.

Top module: `rr_stall_arbiter`

## Requirements
- R1: The grant vector has at most one bit set in every cycle.
- R2: When at least one request bit is set and the stall input is low, the grant vector is nonzero in that same cycle.
- R3: A grant bit is set only where the matching request bit is set in that same cycle.
- R4: While the stall input is high, the grant vector is all zeros, and the priority pointer keeps its value.
- R5: If clients a and b both request and a is granted, a is not granted again until b has been granted, provided b holds its request.
- R6: If every client holds its request until granted, and the stall input is never high for more than MAX_BUSY consecutive cycles, then no request waits MAX_LATENCY = NUM_CLIENTS*(MAX_BUSY+1) cycles or more without a grant.
- R7: After reset, client 0 (request bit 0) has top priority. With all clients requesting, the first grant is bit 0.
- R8: The grant goes to the first requesting client at or after the position one above the last granted index, wrapping from the top index to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| req_i | input | NUM_CLIENTS | One request bit per client; bit i belongs to client i |
| stall_i | input | 1 | Downstream busy; blocks all grants while high |
| gnt_o | output | NUM_CLIENTS | Zero-one-hot grant vector, same-cycle response to req_i |

## Verification
Wrap-around of the pointer is the first target. It is driven with a single client above the pointer and with sparse patterns such as bits 1 and 3 only. A design that forgot the wrap would starve low-index clients or grant a client that is not requesting. Stall cycles are placed in the middle of rotations. A design that advanced its pointer during a stall would skip a client and break the expected order. A second reset is applied after the pointer has moved, to catch a pointer that does not return to client 0. A long random run with held requests and bounded stall bursts tracks pairwise debts and wait times, which exposes any unfair or starving choice.

// File: rtl/arb_pkg.sv
package arb_pkg;

  // Index width for a client count, never below one bit.
  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/rr_pick.sv
module rr_pick
  import arb_pkg::*;
#(
  parameter int NUM_CLIENTS = 4,
  localparam int IW = idx_width(NUM_CLIENTS)
) (
  input  logic [NUM_CLIENTS-1:0] req,
  input  logic [IW-1:0]          ptr,
  output logic [NUM_CLIENTS-1:0] pick,
  output logic [IW-1:0]          pick_idx
);

  logic [NUM_CLIENTS-1:0] upper_mask;
  logic [NUM_CLIENTS-1:0] upper_req;
  logic [NUM_CLIENTS-1:0] search;

  // Clients at or above the pointer form the first search window.
  for (genvar gi = 0; gi < NUM_CLIENTS; gi++) begin : g_mask
    localparam logic [IW:0] POS = (IW+1)'(gi);
    assign upper_mask[gi] = (POS >= {1'b0, ptr});
  end

  always_comb begin
    upper_req = req & upper_mask;
    search    = (|upper_req) ? upper_req : req;
    // Keep the lowest set bit of the chosen window.
    pick      = search & (~search + NUM_CLIENTS'(1));
  end

  always_comb begin
    pick_idx = '0;
    for (int i = 0; i < NUM_CLIENTS; i++) begin
      if (pick[i]) pick_idx = IW'(i);
    end
  end

endmodule

// File: rtl/rr_ptr.sv
module rr_ptr
  import arb_pkg::*;
#(
  parameter int NUM_CLIENTS = 4,
  localparam int IW = idx_width(NUM_CLIENTS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv_en,
  input  logic [IW-1:0] win_idx,
  output logic [IW-1:0] ptr_q
);

  localparam logic [IW-1:0] TOP_IDX = IW'(NUM_CLIENTS - 1);

  logic [IW-1:0] ptr_d;

  always_comb begin
    ptr_d = ptr_q;
    if (adv_en) begin
      ptr_d = (win_idx == TOP_IDX) ? '0 : win_idx + IW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (adv_en) begin
      ptr_q <= ptr_d;
    end
  end

  // R8: the pointer moves only on a granted cycle
  p_ptr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !adv_en |=> $stable(ptr_q));

endmodule

// File: rtl/arb_fair_mon.sv
module arb_fair_mon #(
  parameter int NUM_CLIENTS = 4,
  parameter int MAX_LATENCY = 16,
  localparam int CW = $clog2(MAX_LATENCY + 1) + 1
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [NUM_CLIENTS-1:0] req,
  input logic [NUM_CLIENTS-1:0] gnt
);

  for (genvar gi = 0; gi < NUM_CLIENTS; gi++) begin : g_cli
    logic [CW-1:0] wait_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        wait_q <= '0;
      end else if (gnt[gi] || !req[gi]) begin
        wait_q <= '0;
      end else if (wait_q != '1) begin
        wait_q <= wait_q + CW'(1);
      end
    end

    // R6: bounded wait for a held request
    p_max_wait_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wait_q < CW'(MAX_LATENCY));

    for (genvar gj = 0; gj < NUM_CLIENTS; gj++) begin : g_pair
      if (gi != gj) begin : g_debt
        logic owed_q;

        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            owed_q <= 1'b0;
          end else if (gnt[gj]) begin
            owed_q <= 1'b0;
          end else if (gnt[gi] && req[gj]) begin
            owed_q <= 1'b1;
          end
        end

        // R5: client gi must not win while it still owes client gj a turn
        p_pair_fair_r5: assert property (@(posedge clk) disable iff (!rst_n)
          owed_q |-> !gnt[gi]);
      end
    end
  end

endmodule

// File: rtl/rr_stall_arbiter.sv
module rr_stall_arbiter
  import arb_pkg::*;
#(
  parameter int NUM_CLIENTS = 4,
  parameter int MAX_BUSY    = 3,
  parameter int MAX_LATENCY = NUM_CLIENTS * (MAX_BUSY + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_CLIENTS-1:0] req_i,
  input  logic                   stall_i,
  output logic [NUM_CLIENTS-1:0] gnt_o
);

  localparam int IW = idx_width(NUM_CLIENTS);

  logic [IW-1:0]          ptr_q;
  logic [NUM_CLIENTS-1:0] cand;
  logic [IW-1:0]          cand_idx;
  logic                   grant_en;

  rr_pick #(.NUM_CLIENTS(NUM_CLIENTS)) u_pick (
    .req      (req_i),
    .ptr      (ptr_q),
    .pick     (cand),
    .pick_idx (cand_idx)
  );

  always_comb begin
    grant_en = !stall_i && (|req_i);
    gnt_o    = grant_en ? cand : '0;
  end

  rr_ptr #(.NUM_CLIENTS(NUM_CLIENTS)) u_ptr (
    .clk     (clk),
    .rst_n   (rst_n),
    .adv_en  (grant_en),
    .win_idx (cand_idx),
    .ptr_q   (ptr_q)
  );

  arb_fair_mon #(
    .NUM_CLIENTS (NUM_CLIENTS),
    .MAX_LATENCY (MAX_LATENCY)
  ) u_mon (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (req_i),
    .gnt   (gnt_o)
  );

  p_one_grant_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_o));

  p_no_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((|req_i) && !stall_i) |-> (|gnt_o));

  p_only_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_o & ~req_i) == '0);

  p_stall_block_r4: assert property (@(posedge clk) disable iff (!rst_n)
    stall_i |-> (gnt_o == '0));

  // R7: first grant after reset with full requests lands on client 0
  p_reset_prio_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rst_n) === 1'b0) && (ptr_q == '0) && (&req_i) && !stall_i |-> gnt_o[0]);

endmodule

// File: tb/rr_stall_arbiter_tb.sv
module rr_stall_arbiter_tb_top;

  localparam int N       = 4;
  localparam int MB      = 3;
  localparam int MAX_LAT = N * (MB + 1);

  logic         clk;
  logic         rst_n;
  logic [N-1:0] req;
  logic         stall;
  logic [N-1:0] gnt;

  int checks;
  int errors;
  int ref_ptr;
  bit done;
  int wait_c [N];
  bit owed [N][N];
  logic [N-1:0] last_gnt;

  initial clk = 1'b0;
  always #10 clk = ~clk;

  rr_stall_arbiter #(.NUM_CLIENTS(N), .MAX_BUSY(MB)) dut_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_i   (req),
    .stall_i (stall),
    .gnt_o   (gnt)
  );

  task automatic chk(input bit ok, input string tag,
                     input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic clear_model();
    ref_ptr = 0;
    for (int i = 0; i < N; i++) begin
      wait_c[i] = 0;
      for (int j = 0; j < N; j++) owed[i][j] = 1'b0;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    req   = '0;
    stall = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    clear_model();
  endtask

  task automatic step(input logic [N-1:0] r, input logic b);
    logic [N-1:0] exp;
    bit fair_ok;
    bit lat_ok;
    @(negedge clk);
    req   = r;
    stall = b;
    #2;
    exp = '0;
    if (!b) begin
      for (int k = 0; k < N; k++) begin
        int c;
        c = (ref_ptr + k) % N;
        if (exp == '0 && r[c]) exp[c] = 1'b1;
      end
    end
    last_gnt = gnt;
    chk(gnt == exp, "R8 rotation order", gnt, exp);
    chk($countones(gnt) <= 1, "R1 at most one grant", gnt, exp);
    chk((gnt & ~r) == '0, "R3 grant only to requester", gnt, exp);
    if (b) chk(gnt == '0, "R4 stall blocks grant", gnt, '0);
    if (!b && (|r)) chk(gnt != '0, "R2 grant when free", gnt, exp);
    fair_ok = 1'b1;
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++)
        if (i != j && gnt[i] && owed[i][j]) fair_ok = 1'b0;
    chk(fair_ok, "R5 pairwise fairness", gnt, exp);
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++)
        if (i != j) begin
          if (gnt[j]) owed[i][j] = 1'b0;
          else if (gnt[i] && r[j]) owed[i][j] = 1'b1;
        end
    lat_ok = 1'b1;
    for (int i = 0; i < N; i++) begin
      if (r[i] && !gnt[i]) wait_c[i]++;
      else wait_c[i] = 0;
      if (wait_c[i] >= MAX_LAT) lat_ok = 1'b0;
    end
    chk(lat_ok, "R6 bounded wait", gnt, exp);
    if (exp != '0) begin
      for (int c = 0; c < N; c++) if (exp[c]) ref_ptr = (c + 1) % N;
    end
  endtask

  initial begin
    logic [N-1:0] cur;
    int busy_run;
    checks = 0;
    errors = 0;
    done   = 1'b0;
    rst_n  = 1'b0;
    req    = '0;
    stall  = 1'b0;
    clear_model();
    #3;
    chk(gnt == '0, "R7 idle output in reset", gnt, '0);

    // Full contention after reset: 0,1,2,3 then wrap to 0
    do_reset();
    step(4'b1111, 1'b0);
    chk(last_gnt == 4'b0001, "R7 client 0 first after reset", last_gnt, 4'b0001);
    for (int n = 0; n < 4; n++) step(4'b1111, 1'b0);
    chk(last_gnt == 4'b0001, "R8 wrap from top index", last_gnt, 4'b0001);

    // Stall inside a rotation must not move the pointer
    do_reset();
    step(4'b1111, 1'b0);
    for (int n = 0; n < MB; n++) step(4'b1111, 1'b1);
    step(4'b1111, 1'b0);
    chk(last_gnt == 4'b0010, "R4 pointer held across stall", last_gnt, 4'b0010);

    // Single client above pointer, repeated
    do_reset();
    for (int n = 0; n < 4; n++) step(4'b0100, 1'b0);
    chk(last_gnt == 4'b0100, "R2 lone requester keeps winning", last_gnt, 4'b0100);

    // Sparse pattern
    do_reset();
    for (int n = 0; n < 5; n++) step(4'b1010, 1'b0);
    chk(last_gnt == 4'b0010, "R5 sparse alternation", last_gnt, 4'b0010);

    // Reset after the pointer has moved
    do_reset();
    step(4'b1111, 1'b0);
    step(4'b1111, 1'b0);
    do_reset();
    step(4'b1111, 1'b0);
    chk(last_gnt == 4'b0001, "R7 second reset restores priority", last_gnt, 4'b0001);

    // Random traffic: held requests, bounded stall bursts
    do_reset();
    cur = '0;
    busy_run = 0;
    for (int n = 0; n < 4000; n++) begin
      logic b;
      if (busy_run < MB && ($urandom % 3) == 0) begin
        b = 1'b1;
        busy_run++;
      end else begin
        b = 1'b0;
        busy_run = 0;
      end
      step(cur, b);
      for (int i = 0; i < N; i++) begin
        if (!(cur[i] && !last_gnt[i])) cur[i] = (($urandom % 3) != 0);
      end
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule